// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block sits between a timer's raw PWM level and a pair of power-stage drivers. It produces a true output that is active while the PWM level is high and a complementary output that is active while the PWM level is low. The two outputs never overlap. When the PWM level changes, the output that is leaving its active state drops at once. The output that takes over is held back by a dead time of 2^n system clock cycles, where n is a 3-bit code. Code 0 selects no dead time. Both outputs are active high.

The dead-time code is captured at the start of each dead-time interval. A code change that arrives while an interval is running therefore takes effect at the next PWM edge or enable. If the PWM level toggles while a dead time is still running, the interval restarts. Clearing the enable forces both outputs low and clears the counter. When the enable is set again, the block treats the current PWM level as a fresh edge and runs a full dead time before driving any output.

Top module: `pwm_deadband`

## Requirements
- R1: While the synchronous reset is sampled high, both outputs are low on the following clock edge. The dead-time counter and the captured code are cleared.
- R2: With code 000 captured, the output that takes over follows a PWM change on the same clock edge that samples the change: outTrue = pwmIn and outComp = not pwmIn, with one register of latency.
- R3: With code n from 1 to 7, the output that takes over goes high exactly 2^n clock edges after the edge that sampled the PWM change. This gives 2, 4, 8, 16, 32, 64 or 128 cycles with both outputs low.
- R4: The output that is leaving its active state is low after the first clock edge that samples the PWM change.
- R5: outTrue and outComp are never high in the same cycle.
- R6: A PWM change during a running dead time restarts the count from zero. Neither output goes high until 2^n edges have passed with the PWM level stable.
- R7: While enable is sampled low, both outputs are low after the next edge. The edge that first samples enable high starts a dead time for the current PWM level, and the counting follows R2 and R3.
- R8: The code is captured on the edge that starts a dead time. A different code applied during the interval does not change that interval's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Enables the outputs. When low, both outputs are forced low. |
| pwmIn | input | 1 | Raw PWM level from the timer |
| delayCode | input | 3 | Dead-time code n. The dead time is 0 cycles for code 0 and 2^n cycles otherwise. |
| outTrue | output | 1 | Output that is active while the PWM level is high |
| outComp | output | 1 | Output that is active while the PWM level is low |

## Verification
The bench walks every code from 1 to 7 in both directions. An off-by-one terminal count would show as an output rising one cycle early or late, and a mis-decoded code would give the wrong power of two. It retoggles the PWM inside a running dead time: a design that kept counting, instead of restarting, would drive the new output early. It changes the code in the middle of an interval: a design that compared the count against the live input would end the interval at the wrong cycle. It also drops and restores the enable while an output is active: a design that resumed without a fresh dead time would drive an output straight away.

// File: rtl/pwm_dead_pkg.sv
package pwm_dead_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } dbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLevel;  // capture pwmIn as the held level
    logic loadCode;    // capture the dead-time code
    logic clrCnt;      // clear the dead-time counter
    logic incCnt;      // advance the dead-time counter
    logic dropAll;     // force both outputs inactive
    logic driveNow;    // drive outputs from the live pwm level
    logic driveHeld;   // drive outputs from the held level
  } dbStrobe_t;

endpackage

// File: rtl/pwm_dead_datapath.sv
module pwm_dead_datapath
  import pwm_dead_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dbStrobe_t         strobe,
  input  logic              pwmIn,
  input  logic [CODE_W-1:0] delayCode,
  output logic              levelQ,
  output logic              termHit,
  output logic              codeZero,
  output logic              outTrue,
  output logic              outComp
);

  localparam int CNT_W = 2 ** CODE_W;

  logic [CODE_W-1:0] codeQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  termValue;
  logic              driveLevel;

  // terminal count is 2^codeQ - 1: a thermometer of codeQ ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_term
    assign termValue[i] = (32'(codeQ) > i);
  end

  assign termHit    = (cntQ == termValue);
  assign codeZero   = (delayCode == '0);
  assign driveLevel = strobe.driveNow ? pwmIn : levelQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ  <= 1'b0;
      codeQ   <= '0;
      cntQ    <= '0;
      outTrue <= 1'b0;
      outComp <= 1'b0;
    end else begin
      if (strobe.latchLevel) levelQ <= pwmIn;
      if (strobe.loadCode)   codeQ  <= delayCode;
      if (strobe.clrCnt)      cntQ <= '0;
      else if (strobe.incCnt) cntQ <= cntQ + 1'b1;
      if (strobe.dropAll) begin
        outTrue <= 1'b0;
        outComp <= 1'b0;
      end else if (strobe.driveNow || strobe.driveHeld) begin
        outTrue <= driveLevel;
        outComp <= ~driveLevel;
      end
    end
  end

  // R5: the pair of outputs never overlaps
  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(outTrue && outComp));

  // R6: the counter never runs past the captured terminal value
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cntQ <= termValue);

endmodule

// File: rtl/pwm_dead_control.sv
module pwm_dead_control
  import pwm_dead_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      pwmIn,
  input  logic      levelQ,
  input  logic      termHit,
  input  logic      codeZero,
  output dbStrobe_t strobe,
  output dbState_e  stateQ
);

  dbState_e stateNext;
  logic     startEvt;

  // a fresh dead time starts on enable or on any change of the level
  assign startEvt = enable && ((stateQ == ST_OFF) || (pwmIn != levelQ));

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    if (!enable) begin
      strobe.clrCnt     = 1'b1;
      strobe.dropAll    = 1'b1;
      strobe.latchLevel = 1'b1;
      stateNext         = ST_OFF;
    end else if (startEvt) begin
      strobe.latchLevel = 1'b1;
      strobe.loadCode   = 1'b1;
      strobe.clrCnt     = 1'b1;
      if (codeZero) begin
        strobe.driveNow = 1'b1;
        stateNext       = ST_ON;
      end else begin
        strobe.dropAll  = 1'b1;
        stateNext       = ST_WAIT;
      end
    end else if (stateQ == ST_WAIT) begin
      if (termHit) begin
        strobe.driveHeld = 1'b1;
        stateNext        = ST_ON;
      end else begin
        strobe.incCnt    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_OFF;
    else     stateQ <= stateNext;
  end

  // R6: a change with a nonzero code always (re)enters the waiting state
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (startEvt && !codeZero) |=> (stateQ == ST_WAIT));

  // R7: dropping the enable always leaves the block in the off state
  p_off_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (stateQ == ST_OFF));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_dead_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pwmIn,
  input  logic [CODE_W-1:0] delayCode,
  output logic              outTrue,
  output logic              outComp
);

  dbStrobe_t strobe;
  dbState_e  stateQ;
  logic      levelQ;
  logic      termHit;
  logic      codeZero;

  pwm_dead_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .pwmIn    (pwmIn),
    .levelQ   (levelQ),
    .termHit  (termHit),
    .codeZero (codeZero),
    .strobe   (strobe),
    .stateQ   (stateQ)
  );

  pwm_dead_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pwmIn     (pwmIn),
    .delayCode (delayCode),
    .levelQ    (levelQ),
    .termHit   (termHit),
    .codeZero  (codeZero),
    .outTrue   (outTrue),
    .outComp   (outComp)
  );

  // R4: the leaving output drops on the first edge that sees the change
  p_drop_true_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && outTrue && !pwmIn) |=> !outTrue);
  p_drop_comp_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && outComp && pwmIn) |=> !outComp);

  // R7: disabled means both outputs inactive
  p_disable_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!outTrue && !outComp));

endmodule

// File: tb/pwm_deadband_tb.sv
module pwm_deadband_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       pwmIn = 1'b0;
  logic [2:0] delayCode = 3'd0;
  logic       outTrue;
  logic       outComp;

  always #5 clk = ~clk;

  pwm_deadband u_dut (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .pwmIn     (pwmIn),
    .delayCode (delayCode),
    .outTrue   (outTrue),
    .outComp   (outComp)
  );

  logic [1:0] expQ[$];
  string      tagQ[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  // expectation state, derived from the requirements
  bit mArmed = 0;
  bit mLevel = 0;
  int mStable = 0;
  int mDelay = 0;

  task automatic step(input logic r, input logic e, input logic p,
                      input logic [2:0] c, input string tag);
    logic [1:0] ex;
    @(negedge clk);
    rst = r; enable = e; pwmIn = p; delayCode = c;
    if (r || !e) begin
      mArmed = 0;
      ex = 2'b00;
    end else if (!mArmed || (p != mLevel)) begin
      mArmed = 1; mLevel = p; mStable = 0;
      mDelay = (c == 0) ? 0 : (1 << c);
      ex = (mDelay == 0) ? {p, ~p} : 2'b00;
    end else begin
      mStable++;
      ex = (mStable >= mDelay) ? {mLevel, ~mLevel} : 2'b00;
    end
    expQ.push_back(ex);
    tagQ.push_back(tag);
  endtask

  task automatic hold(input logic p, input logic [2:0] c, input int n,
                      input string firstTag, input string tag);
    for (int j = 0; j < n; j++)
      step(1'b0, 1'b1, p, c, (j == 0) ? firstTag : tag);
  endtask

  // monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [1:0] ex;
        string tg;
        ex = expQ.pop_front();
        tg = tagQ.pop_front();
        checkCnt++;
        if ({outTrue, outComp} !== ex) begin
          failCnt++;
          $display("FAIL %s at %0t: actual=%b%b expected=%b", tg, $time,
                   outTrue, outComp, ex);
        end
        checkCnt++;
        if (outTrue && outComp) begin
          failCnt++;
          $display("FAIL R5 at %0t: actual=11 expected=not both high", $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 3'd5, "R1");
    step(1'b0, 1'b0, 1'b0, 3'd0, "R1");

    // R2: no dead time, several toggles
    hold(1'b0, 3'd0, 3, "R2", "R2");
    hold(1'b1, 3'd0, 2, "R2", "R2");
    hold(1'b0, 3'd0, 1, "R2", "R2");
    hold(1'b1, 3'd0, 1, "R2", "R2");
    hold(1'b0, 3'd0, 4, "R2", "R2");

    // R3 and R4: every nonzero code, both directions
    for (int n = 1; n < 8; n++) begin
      hold(1'b1, 3'(n), (1 << n) + 3, "R4", "R3");
      hold(1'b0, 3'(n), (1 << n) + 3, "R4", "R3");
    end

    // R6: retoggle inside a running dead time (code 3 = 8 cycles)
    hold(1'b1, 3'd3, 5, "R6", "R6");
    hold(1'b0, 3'd3, 3, "R6", "R6");
    hold(1'b1, 3'd3, 7, "R6", "R6");
    hold(1'b0, 3'd3, 12, "R6", "R6");

    // R8: code 4 captured, then changed to 7 during the interval
    hold(1'b1, 3'd4, 1, "R8", "R8");
    hold(1'b1, 3'd7, 20, "R8", "R8");
    hold(1'b0, 3'd1, 4, "R8", "R8");

    // R7: disable while active, then re-enable with code 2
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 3'd2, "R7");
    hold(1'b0, 3'd2, 7, "R7", "R7");
    step(1'b0, 1'b0, 1'b1, 3'd0, "R7");
    hold(1'b1, 3'd0, 3, "R7", "R7");
    step(1'b0, 1'b0, 1'b1, 3'd0, "R7");

    // R1: reset in the middle of activity
    step(1'b1, 1'b1, 1'b1, 3'd0, "R1");
    step(1'b0, 1'b0, 1'b1, 3'd0, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule